// File: doc/BRIEF.md
# Eight-bit interval timer with wrap and match-clear counting

This block is an 8-bit up-counter that advances once on every clock edge where its count enable is high. It has two counting modes. In free-running mode the count runs through the full range, wraps from the top value to zero and records the wrap in an overflow flag. In match-clear mode the count climbs to a programmable match value. On the next enabled edge it returns to zero and records a match flag. Either mode can be used to time a delay, by preloading the count so that a known number of ticks remains before the event.

Software configures the timer through a small write port with a 2-bit register select. The registers are the count (for preloading), the match value, a control register and a write-one-to-clear flag register. The count, the two flags and an interrupt request are always visible on output ports. The interrupt request is raised while any flag is set and its own enable bit in the control register is on.

Top module: `tick_timer8`

## Requirements
- R1: After reset the count is 0x00, both flags are clear and the interrupt request is low. The mode is free-running, the match value is 0x00 and both interrupt enables are off.
- R2: In free-running mode (control bit 0 = 0), each enabled edge adds one to the count. The edge that takes the count from 0xFF to 0x00 also sets the overflow flag (flags bit 0).
- R3: While the count enable is low and no count write occurs, the count holds its value and no flag is set.
- R4: In match-clear mode (control bit 0 = 1), the count climbs by one per enabled edge until it equals the match value. The following enabled edge sets it to 0x00 and sets the match flag (flags bit 1). The cycle is therefore match value + 1 ticks long. A match at 0xFF does not set the overflow flag.
- R5: In match-clear mode, a count above the match value climbs to 0xFF, wraps to 0x00 and sets the overflow flag, then continues up to the match value.
- R6: A write to select 0 loads the count. It takes priority over an increment or a match clear on the same edge, and that edge sets no flag. Preloading 256 − N in free-running mode sets the overflow flag on exactly the Nth enabled edge (0xEC gives 20 ticks).
- R7: A write to select 3 clears the overflow flag where data bit 0 is 1 and the match flag where data bit 1 is 1. Zero bits leave their flag unchanged. A flag set on the same edge as its clear stays set.
- R8: The interrupt request equals (overflow AND control bit 1) OR (match AND control bit 2), combinationally from the flags and the control bits.
- R9: A write to select 1 sets the match value, and a write to select 2 sets the control register. Each takes effect from the next cycle. With no write to them, both hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| count_en | input | 1 | Count enable; one tick per edge while high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 count, 1 match, 2 control, 3 flag clear |
| wr_data | input | 8 | Write data |
| count_o | output | 8 | Current count |
| flags_o | output | 2 | Bit 0 overflow, bit 1 match |
| irq_o | output | 1 | Interrupt request |

## Verification
Every cycle, the assertions check the following. The count steps by exactly one on free-running ticks and holds without a tick. A load always wins. A match edge leaves the count at zero. Flags obey set-wins-over-clear and hold otherwise, and the interrupt is never high with both flags clear. Two properties depend on arithmetic across many ticks, so only the bench can show them. One is that a match value of c gives exactly c + 1 ticks per period. The other is that a preload of 256 − N reaches overflow on exactly the Nth tick. The bench sweeps every match value and every delay length to show both.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned NFLAG      = 2;
  localparam int unsigned FLG_OVF    = 0;
  localparam int unsigned FLG_MATCH  = 1;
  localparam int unsigned CTL_MODE   = 0;
  localparam int unsigned CTL_IE_OVF = 1;
  localparam int unsigned CTL_IE_MAT = 2;

  typedef enum logic [1:0] {
    SEL_COUNT = 2'd0,
    SEL_MATCH = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_FLAGS = 2'd3
  } reg_sel_e;

  typedef enum logic {
    MODE_FREE  = 1'b0,
    MODE_MATCH = 1'b1
  } mode_e;
endpackage

// File: rtl/tmr_ctrl_regs.sv
module tmr_ctrl_regs
  import tmr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [W-1:0]     wr_data,
  output logic             load_o,
  output logic [W-1:0]     load_val_o,
  output logic [NFLAG-1:0] clr_o,
  output logic [W-1:0]     match_val_o,
  output mode_e            mode_o,
  output logic [NFLAG-1:0] ie_o
);
  reg_sel_e sel;
  logic     wr_match, wr_ctrl, wr_flags;

  assign sel      = reg_sel_e'(wr_sel);
  assign load_o   = wr_en && (sel == SEL_COUNT);
  assign wr_match = wr_en && (sel == SEL_MATCH);
  assign wr_ctrl  = wr_en && (sel == SEL_CTRL);
  assign wr_flags = wr_en && (sel == SEL_FLAGS);

  assign load_val_o = wr_data;
  assign clr_o      = wr_flags ? wr_data[NFLAG-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_val_o <= '0;
      mode_o      <= MODE_FREE;
      ie_o        <= '0;
    end else begin
      if (wr_match) match_val_o <= wr_data;
      if (wr_ctrl) begin
        mode_o            <= mode_e'(wr_data[CTL_MODE]);
        ie_o[FLG_OVF]     <= wr_data[CTL_IE_OVF];
        ie_o[FLG_MATCH]   <= wr_data[CTL_IE_MAT];
      end
    end
  end

  // R9: configuration holds without a write to it
  p_match_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_match |=> $stable(match_val_o));
  p_ctrl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> ($stable(mode_o) && $stable(ie_o)));
  p_match_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_match |=> (match_val_o == $past(wr_data)));
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  mode_e        mode,
  input  logic [W-1:0] match_val,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt_o,
  output logic         ev_wrap_o,
  output logic         ev_match_o
);
  localparam logic [W-1:0] TOP = '1;

  function automatic logic f_hit(input mode_e m, input logic [W-1:0] c,
                                 input logic [W-1:0] mv);
    return (m == MODE_MATCH) && (c == mv);
  endfunction

  function automatic logic [W-1:0] f_next(input logic ld, input logic [W-1:0] lv,
                                          input logic adv, input logic hit,
                                          input logic [W-1:0] c);
    if (ld)           return lv;
    else if (adv && hit) return '0;
    else if (adv)     return c + W'(1);
    else              return c;
  endfunction

  logic         adv, hit, at_top;
  logic [W-1:0] cnt_nxt;

  assign adv        = tick && !load;
  assign hit        = f_hit(mode, cnt_o, match_val);
  assign at_top     = (cnt_o == TOP);
  assign ev_match_o = adv && hit;
  assign ev_wrap_o  = adv && !hit && at_top;
  assign cnt_nxt    = f_next(load, load_val, adv, hit, cnt_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_o <= '0;
    else        cnt_o <= cnt_nxt;
  end

  // R6: a load always wins
  p_load_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_o == $past(load_val)));
  // R2: free-running tick adds exactly one (wrapping)
  p_free_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && mode == MODE_FREE) |=> (cnt_o == $past(cnt_o) + W'(1)));
  // R3: no tick, no load, no change
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt_o));
  // R4: a match edge leaves zero
  p_match_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_match_o |=> (cnt_o == '0));
  // R2/R5: a wrap event leaves zero
  p_wrap_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wrap_o |=> (cnt_o == '0));
endmodule

// File: rtl/tmr_flag_reg.sv
module tmr_flag_reg
  import tmr_pkg::*;
#(
  parameter int unsigned N = NFLAG
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_o[i] <= 1'b0;
      else        flag_o[i] <= set_i[i] | (flag_o[i] & ~clr_i[i]);
    end

    // R7: set wins over clear
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> flag_o[i]);
    // R7: a lone clear drops the flag
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !flag_o[i]);
    // R7: no event, no change
    p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i[i] && !set_i[i]) |=> $stable(flag_o[i]));
  end
endmodule

// File: rtl/tick_timer8.sv
module tick_timer8
  import tmr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_en,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [W-1:0]     wr_data,
  output logic [W-1:0]     count_o,
  output logic [NFLAG-1:0] flags_o,
  output logic             irq_o
);
  logic             load;
  logic [W-1:0]     load_val;
  logic [NFLAG-1:0] clr;
  logic [W-1:0]     match_val;
  mode_e            mode;
  logic [NFLAG-1:0] ie;
  logic             ev_wrap, ev_match;
  logic [NFLAG-1:0] set_vec;

  tmr_ctrl_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .load_o(load), .load_val_o(load_val), .clr_o(clr),
    .match_val_o(match_val), .mode_o(mode), .ie_o(ie)
  );

  tmr_count_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(count_en), .mode(mode), .match_val(match_val),
    .load(load), .load_val(load_val), .cnt_o(count_o),
    .ev_wrap_o(ev_wrap), .ev_match_o(ev_match)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[FLG_OVF]   = ev_wrap;
    set_vec[FLG_MATCH] = ev_match;
  end

  tmr_flag_reg #(.N(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr), .flag_o(flags_o)
  );

  assign irq_o = |(flags_o & ie);

  // R8: no request without a pending flag
  p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flags_o != '0));
  // R4/R5: wrap and match never fire together
  p_one_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_wrap, ev_match}));
endmodule

// File: tb/tick_timer8_tb.sv
module tick_timer8_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       count_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] count_o;
  logic [1:0] flags_o;
  logic       irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tick_timer8 u_dut (
    .clk(clk), .rst_n(rst_n), .count_en(count_en), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .count_o(count_o),
    .flags_o(flags_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    if (n > 0) begin
      @(negedge clk);
      count_en = 1'b1;
      for (int i = 1; i < n; i++) @(negedge clk);
      @(negedge clk);
      count_en = 1'b0;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "count", count_o, 0);
    check("R1", "flags", flags_o, 0);
    check("R1", "irq", irq_o, 0);
    rst_n = 1'b1;
    run(3);
    check("R1", "free mode after reset", count_o, 3);
    check("R1", "flags still clear", flags_o, 0);

    // R3 enable low holds
    repeat (5) @(negedge clk);
    check("R3", "count held", count_o, 3);
    check("R3", "no flags", flags_o, 0);

    // R2/R6 delay sweep: preload 256-N, overflow on Nth tick
    for (int n = 1; n <= 256; n++) begin
      wr(2'd3, 8'h03);
      wr(2'd0, 8'((256 - n) & 255));
      run(n - 1);
      check("R6", "no overflow before Nth tick", flags_o[0], 0);
      check("R2", "count before wrap", count_o, 255);
      run(1);
      check("R2", "overflow on Nth tick", flags_o[0], 1);
      check("R2", "wrapped to zero", count_o, 0);
    end
    wr(2'd3, 8'h03);
    wr(2'd0, 8'hEC);
    run(19);
    check("R6", "0xEC after 19 ticks", flags_o[0], 0);
    run(1);
    check("R6", "0xEC after 20 ticks", flags_o[0], 1);

    // R4/R9 match sweep over every match value
    wr(2'd2, 8'h01);
    for (int c = 0; c <= 255; c++) begin
      wr(2'd3, 8'h03);
      wr(2'd1, 8'(c));
      wr(2'd0, 8'h00);
      run(c);
      check("R4", "reached match value", count_o, c);
      check("R4", "no match flag yet", flags_o[1], 0);
      run(1);
      check("R4", "cleared one tick after match", count_o, 0);
      check("R4", "match flag set", flags_o[1], 1);
      check("R4", "no overflow on match clear", flags_o[0], 0);
    end

    // R5 above match value wraps first
    wr(2'd3, 8'h03);
    wr(2'd1, 8'h10);
    wr(2'd0, 8'hFE);
    run(1);
    check("R5", "count FF", count_o, 255);
    run(1);
    check("R5", "wrap to zero", count_o, 0);
    check("R5", "overflow set, match clear", flags_o, 1);
    run(17);
    check("R5", "then match clear", count_o, 0);
    check("R5", "both flags", flags_o, 3);

    // R6 load priority over increment, no event
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h03);
    wr(2'd0, 8'hFF);
    @(negedge clk);
    count_en = 1'b1; wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h10;
    @(negedge clk);
    count_en = 1'b0; wr_en = 1'b0;
    check("R6", "load wins", count_o, 16);
    check("R6", "no overflow on load edge", flags_o[0], 0);

    // R7 W1C and set-wins
    wr(2'd0, 8'hFF);
    run(1);
    check("R7", "ovf set", flags_o, 1);
    wr(2'd3, 8'h02);
    check("R7", "zero bit leaves ovf", flags_o, 1);
    wr(2'd3, 8'h01);
    check("R7", "one bit clears ovf", flags_o, 0);
    wr(2'd0, 8'hFF);
    @(negedge clk);
    count_en = 1'b1; wr_en = 1'b1; wr_sel = 2'd3; wr_data = 8'h01;
    @(negedge clk);
    count_en = 1'b0; wr_en = 1'b0;
    check("R7", "set wins over clear", flags_o[0], 1);

    // R8 interrupt gating
    check("R8", "ovf without enable", irq_o, 0);
    wr(2'd2, 8'h02);
    check("R8", "ovf with enable", irq_o, 1);
    wr(2'd2, 8'h04);
    check("R8", "ovf with match enable only", irq_o, 0);
    wr(2'd3, 8'h03);
    wr(2'd2, 8'h05);
    wr(2'd1, 8'h02);
    wr(2'd0, 8'h00);
    run(3);
    check("R8", "match flag with enable", irq_o, 1);
    wr(2'd3, 8'h02);
    check("R8", "cleared drops request", irq_o, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule